// File: doc/BRIEF.md
# Thermal Overload Shutdown Controller

This block watches a stream of temperature samples and sorts each one into three alarm levels (minor, major, critical). Each level has its own threshold and shares a common hysteresis margin. When the critical level has been reached on enough consecutive samples, the controller applies the overload policy that software has chosen. Under the shutdown policy it drops the main power enable and holds the host in reset. Under the continue policy it keeps the system running. The comparators and the controller itself are assumed to sit on the always-on auxiliary rail, so alarm classification goes on while main power is off.

After a shutdown the controller waits for a sample below a separate recovery threshold. It then enters a restart phase. In that phase main power comes back at once, while the host reset stays asserted for a fixed number of cycles before it is released. Software writes the policy bit through a one-bit write strobe. The value it writes only takes effect while the controller is running, so a change made during shutdown or restart cannot alter the current recovery sequence.

Top module: `thermal_guard`

## Requirements
- R1: After reset all three alarms are low, `ctl_state` is RUN (encoding RUN=0, OFF=1, RESTART=2), `main_pwr_en` is high, `host_rst_n` is high, and the policy is shutdown (`pol_continue`=0 selects shutdown, 1 selects continue).
- R2: A sample (`sample_valid` high) whose temperature is at or above a level's threshold raises that level's alarm on the next clock edge. Each of the three levels is independent.
- R3: A raised alarm clears only on a sample whose temperature is strictly below the threshold minus `hyst_margin`. Samples inside that band leave it raised.
- R4: While `sample_valid` is low, the alarms and the overload detection ignore `temp`.
- R5: Shutdown triggers only after PERSIST_N consecutive samples at or above the critical threshold. Any sample below it restarts the count.
- R6: Under the shutdown policy, the clock edge after the PERSIST_N-th hot sample moves the controller to OFF, with `main_pwr_en` low and `host_rst_n` low.
- R7: Under the continue policy the controller stays in RUN with power on, even while critical samples persist.
- R8: In OFF the alarm levels keep following the samples.
- R9: In OFF, a sample strictly below `recover_thr` moves to RESTART. RESTART drives `main_pwr_en` high and holds `host_rst_n` low for RST_DELAY cycles, then returns to RUN. Samples at or above `recover_thr` keep the controller in OFF.
- R10: The policy written during OFF or RESTART is not applied until the controller has been in RUN for one cycle. On the first RUN cycle the previously applied policy still decides.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sample_valid | input | 1 | `temp` holds a new sample this cycle |
| temp | input | TEMP_W | Temperature sample, unsigned |
| minor_thr | input | TEMP_W | Minor alarm threshold |
| major_thr | input | TEMP_W | Major alarm threshold |
| crit_thr | input | TEMP_W | Critical threshold, also the overload trigger |
| hyst_margin | input | HYST_W | Clear margin below each threshold |
| recover_thr | input | TEMP_W | Temperature below which recovery starts |
| pol_wr | input | 1 | Write strobe for the policy bit |
| pol_continue | input | 1 | Policy value written: 1 continue, 0 shutdown |
| alarm_minor | output | 1 | Minor alarm |
| alarm_major | output | 1 | Major alarm |
| alarm_crit | output | 1 | Critical alarm |
| main_pwr_en | output | 1 | Main power enable |
| host_rst_n | output | 1 | Active-low host reset |
| ctl_state | output | 2 | Controller state: RUN=0, OFF=1, RESTART=2 |

## Verification
On every cycle the assertions check four things. Held alarms do not change without a sample. A hot sample raises the critical alarm. The controller leaves RUN for OFF only after a full run of hot samples, and OFF is left only on a cool sample and never straight into RUN. The applied policy is frozen outside RUN, and the continue policy keeps the controller in RUN. Only the bench scenarios can show how long the host reset stays asserted during restart and how the hysteresis bands behave at each threshold. They also cover the case where a policy rewritten during shutdown loses to the frozen policy on the first running cycle.

// File: rtl/thermal_guard_pkg.sv
// Shared types for the thermal overload controller.
package thermal_guard_pkg;
    typedef enum logic [1:0] {
        ST_RUN     = 2'd0,
        ST_OFF     = 2'd1,
        ST_RESTART = 2'd2
    } tg_state_e;

    localparam int NUM_LEVELS = 3;   // index 0 minor, 1 major, 2 critical
    localparam int LVL_CRIT   = 2;
endpackage

// File: rtl/tg_level.sv
// One alarm level with hysteresis. Sets on a sample at or above thr and
// clears on a sample below thr - hyst. Holds between samples.
// Assumes TEMP_W + 1 > HYST_W.
module tg_level #(
    parameter int TEMP_W = 10,
    parameter int HYST_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_valid,
    input  logic [TEMP_W-1:0] temp,
    input  logic [TEMP_W-1:0] thr,
    input  logic [HYST_W-1:0] hyst,
    output logic              alarm
);
    localparam int PAD_W = TEMP_W + 1 - HYST_W;

    logic [TEMP_W:0] temp_plus_hyst;

    // Widened sum avoids the underflow of thr - hyst.
    always_comb temp_plus_hyst = {1'b0, temp} + {{PAD_W{1'b0}}, hyst};

    // Alarm flop: set on hot samples, clear below the band.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alarm <= 1'b0;
        end else if (sample_valid) begin
            if (temp >= thr) begin
                alarm <= 1'b1;
            end else if (temp_plus_hyst < {1'b0, thr}) begin
                alarm <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/tg_persist.sv
// Counts consecutive samples at or above the critical threshold,
// saturating at PERSIST_N. trip is high once the count is full.
module tg_persist #(
    parameter int TEMP_W    = 10,
    parameter int PERSIST_N = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_valid,
    input  logic [TEMP_W-1:0] temp,
    input  logic [TEMP_W-1:0] crit_thr,
    output logic              trip
);
    localparam int CNT_W = $clog2(PERSIST_N + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(PERSIST_N);

    logic [CNT_W-1:0] run_cnt;

    // Consecutive-hot counter; a cool sample restarts it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_cnt <= '0;
        end else if (sample_valid) begin
            if (temp < crit_thr) begin
                run_cnt <= '0;
            end else if (run_cnt != CNT_MAX) begin
                run_cnt <= run_cnt + 1'b1;
            end
        end
    end

    // Trip level from the registered count.
    always_comb trip = (run_cnt == CNT_MAX);
endmodule

// File: rtl/tg_fsm.sv
// Policy register and run / off / restart sequencer. The applied policy
// follows the written bit only while in RUN. RESTART powers main rails
// and holds host reset for RST_DELAY cycles. Assumes RST_DELAY >= 1.
module tg_fsm
    import thermal_guard_pkg::*;
#(
    parameter int RST_DELAY = 4
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      trip,
    input  logic      cool,
    input  logic      pol_wr,
    input  logic      pol_continue,
    output tg_state_e state,
    output logic      eff_policy,
    output logic      main_pwr_en,
    output logic      host_rst_n
);
    localparam int TMR_W = $clog2(RST_DELAY + 1);
    localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(RST_DELAY - 1);

    tg_state_e        state_nx;
    logic [TMR_W-1:0] tmr, tmr_nx;
    logic             pol_reg;

    // Software-written policy bit, shutdown after reset.
    always_ff @(posedge clk) begin
        if (!rst_n)      pol_reg <= 1'b0;
        else if (pol_wr) pol_reg <= pol_continue;
    end

    // Applied policy, sampled from the register only while running.
    always_ff @(posedge clk) begin
        if (!rst_n)                eff_policy <= 1'b0;
        else if (state == ST_RUN)  eff_policy <= pol_reg;
    end

    // Next-state and restart timer logic.
    always_comb begin
        state_nx = state;
        tmr_nx   = tmr;
        unique case (state)
            ST_RUN: begin
                if (trip && !eff_policy) state_nx = ST_OFF;
            end
            ST_OFF: begin
                if (cool) begin
                    state_nx = ST_RESTART;
                    tmr_nx   = '0;
                end
            end
            ST_RESTART: begin
                if (tmr == TMR_LAST) state_nx = ST_RUN;
                else                 tmr_nx   = tmr + 1'b1;
            end
            default: state_nx = ST_RUN;
        endcase
    end

    // State and timer registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_RUN;
            tmr   <= '0;
        end else begin
            state <= state_nx;
            tmr   <= tmr_nx;
        end
    end

    // Power and reset outputs decoded from the state register.
    always_comb begin
        main_pwr_en = (state != ST_OFF);
        host_rst_n  = (state == ST_RUN);
    end
endmodule

// File: rtl/thermal_guard.sv
// Thermal overload controller top: three hysteresis alarm levels, a
// persistence filter on the critical level, and the policy sequencer.
// Assumes samples arrive as single-cycle sample_valid strobes.
module thermal_guard
    import thermal_guard_pkg::*;
#(
    parameter int TEMP_W    = 10,
    parameter int HYST_W    = 6,
    parameter int PERSIST_N = 3,
    parameter int RST_DELAY = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_valid,
    input  logic [TEMP_W-1:0] temp,
    input  logic [TEMP_W-1:0] minor_thr,
    input  logic [TEMP_W-1:0] major_thr,
    input  logic [TEMP_W-1:0] crit_thr,
    input  logic [HYST_W-1:0] hyst_margin,
    input  logic [TEMP_W-1:0] recover_thr,
    input  logic              pol_wr,
    input  logic              pol_continue,
    output logic              alarm_minor,
    output logic              alarm_major,
    output logic              alarm_crit,
    output logic              main_pwr_en,
    output logic              host_rst_n,
    output logic [1:0]        ctl_state
);
    logic [TEMP_W-1:0]     thr_vec [NUM_LEVELS];
    logic [NUM_LEVELS-1:0] alarm_vec;
    logic                  trip;
    logic                  cool;
    logic                  eff_policy;
    tg_state_e             state;

    // Threshold gathering for the level array.
    always_comb begin
        thr_vec[0] = minor_thr;
        thr_vec[1] = major_thr;
        thr_vec[2] = crit_thr;
    end

    for (genvar g = 0; g < NUM_LEVELS; g++) begin : g_lvl
        tg_level #(.TEMP_W(TEMP_W), .HYST_W(HYST_W)) u_lvl (
            .clk(clk), .rst_n(rst_n), .sample_valid(sample_valid),
            .temp(temp), .thr(thr_vec[g]), .hyst(hyst_margin),
            .alarm(alarm_vec[g])
        );
    end

    tg_persist #(.TEMP_W(TEMP_W), .PERSIST_N(PERSIST_N)) u_persist (
        .clk(clk), .rst_n(rst_n), .sample_valid(sample_valid),
        .temp(temp), .crit_thr(crit_thr), .trip(trip)
    );

    // Recovery qualifier: a valid sample below the recovery threshold.
    always_comb cool = sample_valid && (temp < recover_thr);

    tg_fsm #(.RST_DELAY(RST_DELAY)) u_fsm (
        .clk(clk), .rst_n(rst_n), .trip(trip), .cool(cool),
        .pol_wr(pol_wr), .pol_continue(pol_continue),
        .state(state), .eff_policy(eff_policy),
        .main_pwr_en(main_pwr_en), .host_rst_n(host_rst_n)
    );

    // Output mapping.
    always_comb begin
        alarm_minor = alarm_vec[0];
        alarm_major = alarm_vec[1];
        alarm_crit  = alarm_vec[LVL_CRIT];
        ctl_state   = state;
    end
endmodule

// File: rtl/thermal_guard_chk.sv
// Checker for thermal_guard, attached by bind. It keeps its own count of
// consecutive hot samples to judge when a shutdown is allowed.
module thermal_guard_chk
    import thermal_guard_pkg::*;
#(
    parameter int TEMP_W    = 10,
    parameter int PERSIST_N = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sample_valid,
    input logic [TEMP_W-1:0] temp,
    input logic [TEMP_W-1:0] crit_thr,
    input logic [TEMP_W-1:0] recover_thr,
    input logic              alarm_minor,
    input logic              alarm_major,
    input logic              alarm_crit,
    input logic [1:0]        ctl_state,
    input logic              eff_policy
);
    localparam int CW = $clog2(PERSIST_N + 1);
    localparam logic [CW-1:0] FULL = CW'(PERSIST_N);

    logic [CW-1:0] hot_run;

    // Independent consecutive-hot-sample counter.
    always_ff @(posedge clk) begin
        if (!rst_n) hot_run <= '0;
        else if (sample_valid) begin
            if (temp < crit_thr)    hot_run <= '0;
            else if (hot_run != FULL) hot_run <= hot_run + 1'b1;
        end
    end

    a_r4_alarms_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_valid |=> $stable({alarm_minor, alarm_major, alarm_crit}));

    a_r2_crit_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_valid && temp >= crit_thr) |=> alarm_crit);

    a_r5_trip_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_state == ST_OFF && $past(ctl_state) == ST_RUN) |-> $past(hot_run) == FULL);

    a_r9_off_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_state == ST_OFF && !(sample_valid && temp < recover_thr)) |=> ctl_state == ST_OFF);

    a_r9_no_skip_restart: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_state == ST_OFF |=> ctl_state != ST_RUN);

    a_r10_policy_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_state != ST_RUN |=> $stable(eff_policy));

    a_r7_continue_runs: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_state == ST_RUN && eff_policy) |=> ctl_state == ST_RUN);
endmodule

bind thermal_guard thermal_guard_chk #(.TEMP_W(TEMP_W), .PERSIST_N(PERSIST_N)) u_chk (
    .clk(clk), .rst_n(rst_n), .sample_valid(sample_valid), .temp(temp),
    .crit_thr(crit_thr), .recover_thr(recover_thr),
    .alarm_minor(alarm_minor), .alarm_major(alarm_major), .alarm_crit(alarm_crit),
    .ctl_state(ctl_state), .eff_policy(eff_policy)
);

// File: tb/sim_thermal_guard.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver applies a cycle, updates a requirement
// model and queues the expected outputs; a monitor compares them.
module sim_thermal_guard;
    localparam int TW = 10, HW = 6, PN = 3, RD = 4;
    localparam int MINOR = 60, MAJOR = 80, CRIT = 100, HYST = 5, REC = 70;

    logic clk = 1'b0, rst_n = 1'b0;
    logic sample_valid = 1'b0, pol_wr = 1'b0, pol_continue = 1'b0;
    logic [TW-1:0] temp = '0;
    logic alarm_minor, alarm_major, alarm_crit, main_pwr_en, host_rst_n;
    logic [1:0] ctl_state;

    always #2.5 clk = ~clk;

    thermal_guard #(.TEMP_W(TW), .HYST_W(HW), .PERSIST_N(PN), .RST_DELAY(RD)) u0 (
        .clk(clk), .rst_n(rst_n), .sample_valid(sample_valid), .temp(temp),
        .minor_thr(TW'(MINOR)), .major_thr(TW'(MAJOR)), .crit_thr(TW'(CRIT)),
        .hyst_margin(HW'(HYST)), .recover_thr(TW'(REC)),
        .pol_wr(pol_wr), .pol_continue(pol_continue),
        .alarm_minor(alarm_minor), .alarm_major(alarm_major), .alarm_crit(alarm_crit),
        .main_pwr_en(main_pwr_en), .host_rst_n(host_rst_n), .ctl_state(ctl_state)
    );

    typedef struct {
        string      tag;
        logic [2:0] al;
        logic       pwr;
        logic       hrst;
        logic [1:0] st;
    } exp_t;

    exp_t q[$];
    int n_cmp = 0, n_bad = 0;
    bit done = 0;

    // Requirement model state (RUN=0, OFF=1, RESTART=2).
    bit m_al[3];
    int m_cnt = 0, m_st = 0, m_tmr = 0;
    bit m_eff = 0, m_pol = 0;
    int thr_m[3] = '{MINOR, MAJOR, CRIT};

    task automatic tick(input bit sv, input int t, input bit wr, input bit wd, input string tag);
        exp_t e;
        bit trip;
        int old_st;
        @(negedge clk);
        sample_valid = sv; temp = TW'(t); pol_wr = wr; pol_continue = wd;
        @(posedge clk);
        old_st = m_st;
        trip = (m_cnt >= PN);
        case (m_st)
            0: if (trip && !m_eff) m_st = 1;
            1: if (sv && t < REC) begin m_st = 2; m_tmr = 0; end
            default: if (m_tmr == RD - 1) m_st = 0; else m_tmr++;
        endcase
        if (old_st == 0) m_eff = m_pol;
        if (wr) m_pol = wd;
        if (sv) begin
            m_cnt = (t >= CRIT) ? ((m_cnt < PN) ? m_cnt + 1 : PN) : 0;
            for (int i = 0; i < 3; i++) begin
                if (t >= thr_m[i]) m_al[i] = 1;
                else if (t + HYST < thr_m[i]) m_al[i] = 0;
            end
        end
        e.tag = tag;
        e.al = {m_al[2], m_al[1], m_al[0]};
        e.pwr = (m_st != 1);
        e.hrst = (m_st == 0);
        e.st = 2'(m_st);
        q.push_back(e);
    endtask

    // Monitor: compares queued expectations away from the active edge.
    initial begin
        forever begin
            @(negedge clk);
            while (q.size() > 0) begin
                exp_t e;
                logic [2:0] a;
                e = q.pop_front();
                a = {alarm_crit, alarm_major, alarm_minor};
                n_cmp++;
                if (a !== e.al || main_pwr_en !== e.pwr || host_rst_n !== e.hrst || ctl_state !== e.st) begin
                    n_bad++;
                    $display("FAIL %s: got alarms=%b pwr=%b hrst=%b st=%0d, expected alarms=%b pwr=%b hrst=%b st=%0d",
                             e.tag, a, main_pwr_en, host_rst_n, ctl_state, e.al, e.pwr, e.hrst, e.st);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        tick(0, 0, 0, 0, "R1");
        // Alarm levels and hysteresis.
        tick(1, 65, 0, 0, "R2");
        tick(1, 85, 0, 0, "R2");
        tick(1, 101, 0, 0, "R2");
        tick(1, 62, 0, 0, "R3");
        tick(1, 57, 0, 0, "R3");
        tick(1, 54, 0, 0, "R3");
        // Idle cycles with a hot value on temp.
        tick(0, 200, 0, 0, "R4");
        tick(0, 200, 0, 0, "R4");
        // Persistence with an interrupted run, then a full run.
        tick(1, 105, 0, 0, "R5");
        tick(1, 105, 0, 0, "R5");
        tick(1, 96, 0, 0, "R5");
        tick(1, 105, 0, 0, "R5");
        tick(1, 105, 0, 0, "R5");
        tick(1, 105, 0, 0, "R5");
        tick(0, 0, 0, 0, "R6");
        // Monitoring in OFF, policy write while off, recovery.
        tick(1, 85, 0, 0, "R8");
        tick(0, 0, 1, 1, "R10");
        tick(1, 72, 0, 0, "R9");
        tick(1, 65, 0, 0, "R9");
        tick(1, 105, 0, 0, "R10");
        tick(1, 105, 0, 0, "R10");
        tick(1, 105, 0, 0, "R10");
        tick(0, 0, 0, 0, "R10");
        tick(0, 0, 0, 0, "R10");
        // Second recovery, now with continue applied.
        tick(1, 65, 0, 0, "R9");
        for (int i = 0; i < 4; i++) tick(0, 0, 0, 0, "R9");
        tick(1, 105, 0, 0, "R7");
        tick(1, 105, 0, 0, "R7");
        tick(1, 105, 0, 0, "R7");
        tick(0, 0, 0, 0, "R7");
        tick(0, 0, 0, 0, "R7");
        // Back to shutdown policy while hot.
        tick(0, 0, 1, 0, "R6");
        tick(0, 0, 0, 0, "R6");
        tick(0, 0, 0, 0, "R6");
        repeat (3) @(negedge clk);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule